// File: doc/BRIEF.md
# Serial Programming Target Interface

This block is the device-side end of a two-wire in-system programming link for a 12-bit-word flash array. A host toggles a serial clock pin and presents data on a data pin. The block samples both pins with the system clock and detects the clock edges itself. On the falling edges it shifts in a 6-bit command. Load and read commands are followed by a 16-clock data segment: the block either captures a word into a four-entry row latch, or drives the currently addressed word back out.

The block owns the address counter, which can only move forward. It presents a word-wide memory port: address, write data, write strobe and read data. It also raises a one-cycle erase strobe for the memory. A programming command writes the whole four-word row around the counter. Code protection is an input taken from the configuration word. Programming mode is entered and left with a synchronous enable.

The control state machine has five states. OFF is held whenever the mode enable is low. CMD receives a command. LOAD receives a data segment. READ sends a data segment. PROG issues the row writes. The transitions are as follows. OFF goes to CMD once enable is high. CMD goes to LOAD, READ or PROG when a load, read or begin-programming code is decoded, and stays in CMD for every other code. LOAD and READ return to CMD on the 16th falling edge of the segment. PROG returns to CMD after its fourth write cycle. Every state goes to OFF when enable drops.

Top module: `spt_target`

## Requirements
- R1: A command is six serial clocks. On each falling edge one bit is taken, bit 0 first. Only bits 3:0 select the command, and bits 5:4 are don't care. The codes are: 0x2 load, 0x4 read, 0x6 increment, 0x8 begin programming, 0xE end programming, 0x9 bulk erase.
- R2: Any other 4-bit code causes no counter change, no write strobe and no erase strobe.
- R3: A load segment is 16 clocks. The first and the 16th falling edges are ignored. The 14 edges between them carry bits 0 to 13, bit 0 first. Bits 13:12 are dropped, and bits 11:0 go into the row latch entry selected by counter bits 1:0.
- R4: On a read, the data pin output enable rises at the 2nd rising edge of the segment and falls at the 16th. Rising edges 2 to 15 present bits 0 to 13, bit 0 first. Bits 13:12 always read as 1.
- R5: On mode entry the counter is 0xFFF. Each increment adds one, so 0xFFF wraps to 0x000 and 0x7FF moves on to 0x800.
- R6: After the first increment since mode entry, address 0xFFF is hidden. Reads there return 0xFFF in bits 11:0, and row writes issue no strobe for that address.
- R7: With code protection on, reads of 0x040 to 0x7FF return zero in bits 11:0. Reads of 0x000 to 0x03F and of 0x800 and above are unaffected.
- R8: Begin programming issues four write strobes on consecutive cycles. They go to addresses {counter[11:2], 0..3} and carry the row latch entries 0..3.
- R9: End programming sets every row latch entry to all ones.
- R10: Bulk erase raises the erase strobe for exactly one cycle.
- R11: Leaving mode entry abandons any partial command or segment. It releases the data pin, resets the counter to 0xFFF and resets the latches to ones. A command that completes in the same cycle that enable drops has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_en | input | 1 | Programming mode enable |
| sclk | input | 1 | Serial clock pin level |
| sdat_in | input | 1 | Serial data pin level |
| sdat_out | output | 1 | Serial data output value |
| sdat_oe | output | 1 | Serial data output enable |
| mem_addr | output | 12 | Memory word address |
| mem_wdata | output | 12 | Memory write data |
| mem_we | output | 1 | Memory write strobe, one word per cycle |
| mem_rdata | input | 12 | Memory read data, combinational from mem_addr |
| code_prot | input | 1 | Code protection active |
| erase_stb | output | 1 | Bulk erase strobe |

## Verification
The 6th falling edge of a command, which triggers the decode, can land in the same system cycle in which the mode enable drops. The bench provokes this by driving the last clock low and enable low on the same edge, with an increment code in flight. It judges the result by re-entering the mode and reading. The configuration word must still be returned unhidden, which shows that the counter neither moved nor lost access to 0xFFF. A second case drops enable after three command bits. The next full read after re-entry must then be framed correctly.

// File: rtl/spt_pkg.sv
package spt_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_CMD,
        ST_LOAD,
        ST_READ,
        ST_PROG
    } spt_state_e;

    localparam logic [3:0] OP_LOAD  = 4'h2;
    localparam logic [3:0] OP_READ  = 4'h4;
    localparam logic [3:0] OP_INCR  = 4'h6;
    localparam logic [3:0] OP_BEGIN = 4'h8;
    localparam logic [3:0] OP_END   = 4'hE;
    localparam logic [3:0] OP_ERASE = 4'h9;

    function automatic logic op_known(input logic [3:0] op);
        return (op == OP_LOAD) || (op == OP_READ) || (op == OP_INCR) ||
               (op == OP_BEGIN) || (op == OP_END) || (op == OP_ERASE);
    endfunction

endpackage

// File: rtl/spt_edge.sv
module spt_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    // Track the pin while disabled so that entry never sees a false edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = en && sclk && !sclk_q;
    assign fall = en && !sclk && sclk_q;
endmodule

// File: rtl/spt_pc.sv
module spt_pc #(
    parameter int AW       = 12,
    parameter int USER_TOP = 'h7FF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          inc,
    output logic [AW-1:0] pc,
    output logic          cfg_ok
);
    localparam logic [AW-1:0] U_TOP = AW'(USER_TOP);

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pc     <= '1;
            cfg_ok <= 1'b1;
        end else if (inc) begin
            pc     <= pc + AW'(1);
            cfg_ok <= 1'b0;
        end
    end

    // R5
    pc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (inc && pc == '1) |=> pc == '0);
    // R5
    pc_cfg_jump_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (inc && pc == U_TOP) |=> pc == U_TOP + AW'(1));
    // R2
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        !inc |=> $stable(pc));
    // R6
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        !cfg_ok |=> !cfg_ok);
endmodule

// File: rtl/spt_latch.sv
module spt_latch #(
    parameter int DW = 12,
    parameter int RW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wr,
    input  logic [RW-1:0] wsel,
    input  logic [DW-1:0] wdata,
    input  logic          fill,
    input  logic [RW-1:0] rsel,
    output logic [DW-1:0] rdata
);
    localparam int ROWS = 1 << RW;

    logic [DW-1:0] lat_q [ROWS];

    for (genvar g = 0; g < ROWS; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n || !en || fill)            lat_q[g] <= '1;
            else if (wr && wsel == RW'(g))         lat_q[g] <= wdata;
        end

        // R9
        fill_ones_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
            fill |=> lat_q[g] == '1);
        // R3
        load_store_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
            (wr && !fill && wsel == RW'(g)) |=> lat_q[g] == $past(wdata));
    end

    assign rdata = lat_q[rsel];
endmodule

// File: rtl/spt_target.sv
module spt_target
    import spt_pkg::*;
#(
    parameter int AW       = 12,
    parameter int DW       = 12,
    parameter int SW       = 14,
    parameter int CW       = 6,
    parameter int RW       = 2,
    parameter int USER_TOP = 'h7FF,
    parameter int PROT_TOP = 'h03F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_en,
    input  logic          sclk,
    input  logic          sdat_in,
    output logic          sdat_out,
    output logic          sdat_oe,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    input  logic          code_prot,
    output logic          erase_stb
);
    localparam int CNTW = $clog2(SW + 2);
    localparam int PAD  = SW - DW;
    localparam logic [CNTW-1:0] ONE      = CNTW'(1);
    localparam logic [CNTW-1:0] CMD_LAST = CNTW'(CW - 1);
    localparam logic [CNTW-1:0] BIT_LAST = CNTW'(SW);
    localparam logic [CNTW-1:0] SEG_LAST = CNTW'(SW + 1);
    localparam logic [AW-1:0]   U_TOP    = AW'(USER_TOP);
    localparam logic [AW-1:0]   P_TOP    = AW'(PROT_TOP);

    spt_state_e     state_q, state_d;
    logic [CNTW-1:0] cnt_q;
    logic [SW-1:0]  sh_q;
    logic [RW-1:0]  idx_q;
    logic           rise, fall;
    logic [AW-1:0]  pc;
    logic           cfg_ok;
    logic [3:0]     op;
    logic           cmd_done, inc_go, fill_go, ld_go;
    logic [DW-1:0]  rd_word, lat_rd;

    spt_edge u_edge (
        .clk(clk), .rst_n(rst_n), .en(prog_en), .sclk(sclk),
        .rise(rise), .fall(fall)
    );

    spt_pc #(.AW(AW), .USER_TOP(USER_TOP)) u_pc (
        .clk(clk), .rst_n(rst_n), .en(prog_en), .inc(inc_go),
        .pc(pc), .cfg_ok(cfg_ok)
    );

    spt_latch #(.DW(DW), .RW(RW)) u_latch (
        .clk(clk), .rst_n(rst_n), .en(prog_en),
        .wr(ld_go), .wsel(pc[RW-1:0]), .wdata(sh_q[DW-1:0]),
        .fill(fill_go), .rsel(idx_q), .rdata(lat_rd)
    );

    // Command bits 3:0 are already latched when the sixth edge arrives.
    assign op       = sh_q[3:0];
    assign cmd_done = (state_q == ST_CMD) && fall && (cnt_q == CMD_LAST);
    assign inc_go   = cmd_done && (op == OP_INCR);
    assign fill_go  = cmd_done && (op == OP_END);
    assign ld_go    = (state_q == ST_LOAD) && fall && (cnt_q == SEG_LAST);

    always_comb begin
        if (pc == '1 && !cfg_ok)                          rd_word = '1;
        else if (code_prot && pc > P_TOP && pc <= U_TOP)  rd_word = '0;
        else                                              rd_word = mem_rdata;
    end

    assign mem_addr  = (state_q == ST_PROG) ? {pc[AW-1:RW], idx_q} : pc;
    assign mem_wdata = lat_rd;
    assign mem_we    = prog_en && (state_q == ST_PROG) && !(mem_addr == '1 && !cfg_ok);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  state_d = ST_CMD;
            ST_CMD: begin
                if (cmd_done) begin
                    if (op == OP_LOAD)       state_d = ST_LOAD;
                    else if (op == OP_READ)  state_d = ST_READ;
                    else if (op == OP_BEGIN) state_d = ST_PROG;
                end
            end
            ST_LOAD, ST_READ: if (fall && cnt_q == SEG_LAST) state_d = ST_CMD;
            ST_PROG: if (idx_q == '1) state_d = ST_CMD;
            default: state_d = ST_OFF;
        endcase
        if (!prog_en) state_d = ST_OFF;
    end

    // Datapath and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n || !prog_en) begin
            cnt_q     <= '0;
            sh_q      <= '0;
            idx_q     <= '0;
            sdat_oe   <= 1'b0;
            sdat_out  <= 1'b0;
            erase_stb <= 1'b0;
        end else begin
            erase_stb <= cmd_done && (op == OP_ERASE);
            unique case (state_q)
                ST_OFF: cnt_q <= '0;
                ST_CMD: begin
                    if (fall) begin
                        sh_q[cnt_q] <= sdat_in;
                        if (cnt_q == CMD_LAST) begin
                            cnt_q <= '0;
                            if (op == OP_READ) sh_q <= {{PAD{1'b1}}, rd_word};
                        end else begin
                            cnt_q <= cnt_q + ONE;
                        end
                    end
                end
                ST_LOAD: begin
                    if (fall) begin
                        if (cnt_q != '0 && cnt_q <= BIT_LAST) sh_q[cnt_q - ONE] <= sdat_in;
                        cnt_q <= (cnt_q == SEG_LAST) ? '0 : cnt_q + ONE;
                    end
                end
                ST_READ: begin
                    if (rise) begin
                        if (cnt_q != '0 && cnt_q <= BIT_LAST) begin
                            sdat_oe  <= 1'b1;
                            sdat_out <= sh_q[0];
                            sh_q     <= sh_q >> 1;
                        end else if (cnt_q == SEG_LAST) begin
                            sdat_oe  <= 1'b0;
                            sdat_out <= 1'b0;
                        end
                    end
                    if (fall) cnt_q <= (cnt_q == SEG_LAST) ? '0 : cnt_q + ONE;
                end
                ST_PROG: idx_q <= idx_q + RW'(1);
                default: cnt_q <= '0;
            endcase
        end
    end

    // R4
    oe_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sdat_oe |-> state_q == ST_READ);
    // R8
    we_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> state_q == ST_PROG);
    // R10
    erase_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_stb |=> !erase_stb);
    // R2
    unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !prog_en)
        (cmd_done && !op_known(op)) |=> (state_q == ST_CMD && !erase_stb && !mem_we));
    // R11
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_en |=> (!sdat_oe && !mem_we && !erase_stb && state_q == ST_OFF));
    // R1
    load_entry_chk: assert property (@(posedge clk) disable iff (!rst_n || !prog_en)
        (cmd_done && op == OP_LOAD) |=> state_q == ST_LOAD);
endmodule

// File: tb/spt_target_tb_top.sv
module spt_target_tb_top;
    logic        clk = 1'b0;
    logic        rst_n, prog_en, sclk, sdat_in;
    logic        sdat_out, sdat_oe, mem_we, erase_stb, code_prot;
    logic [11:0] mem_addr, mem_wdata, mem_rdata;
    logic [11:0] mem [4096];
    int          n_chk = 0, n_fail = 0, we_cnt = 0, er_cnt = 0;
    bit          done = 1'b0;

    typedef struct {
        logic [13:0] w;
        string       tag;
    } exp_t;
    exp_t        exp_q[$];
    event        rd_ev;
    logic [13:0] got;

    always #2 clk = ~clk;

    spt_target dut_i (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .sclk(sclk), .sdat_in(sdat_in),
        .sdat_out(sdat_out), .sdat_oe(sdat_oe), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .code_prot(code_prot), .erase_stb(erase_stb)
    );

    // Behavioural flash: writes can only clear bits, erase sets user space and 0xFFF.
    assign mem_rdata = mem[mem_addr];
    assign code_prot = ~mem[12'hFFF][3];

    initial begin
        for (int a = 0; a < 4096; a++) begin
            if (a >= 'h800 && a <= 'h803) mem[a] = 12'h5A5;
            else if (a == 'hFFF)          mem[a] = 12'hFFF;
            else                          mem[a] = 12'h000;
        end
    end

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem[mem_addr] & mem_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (erase_stb) begin
            for (int a = 0; a <= 'h7FF; a++) mem[a] <= 12'hFFF;
            mem[12'hFFF] <= 12'hFFF;
            er_cnt <= er_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: pops the expected word for each completed read.
    initial begin
        forever begin
            exp_t e;
            @(rd_ev);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected read", 32'(got), 32'h0);
            end else begin
                e = exp_q.pop_front();
                chk(got == e.w, e.tag, 32'(got), 32'(e.w));
            end
        end
    end

    task automatic bitclk(input logic d);
        sdat_in = d;
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_cmd(input logic [5:0] c);
        for (int i = 0; i < 6; i++) bitclk(c[i]);
        repeat (2) @(negedge clk);
    endtask

    task automatic inc_n(input int n);
        for (int i = 0; i < n; i++) send_cmd(6'h06);
    endtask

    task automatic load_word(input logic [13:0] w);
        send_cmd(6'h02);
        bitclk(1'b1);
        for (int i = 0; i < 14; i++) bitclk(w[i]);
        bitclk(1'b1);
        repeat (2) @(negedge clk);
    endtask

    // Driver: pushes the expectation, then clocks the read segment.
    task automatic read_exp(input logic [13:0] w, input string tag);
        exp_t e;
        e.w = w;
        e.tag = tag;
        exp_q.push_back(e);
        send_cmd(6'h04);
        for (int k = 1; k <= 16; k++) begin
            sclk = 1'b1;
            repeat (2) @(negedge clk);
            if (k == 1)  chk(sdat_oe == 1'b0, "R4 oe before 2nd rise", 32'(sdat_oe), 32'h0);
            if (k == 2)  chk(sdat_oe == 1'b1, "R4 oe at 2nd rise", 32'(sdat_oe), 32'h1);
            if (k >= 2 && k <= 15) got[k-2] = sdat_out;
            if (k == 16) chk(sdat_oe == 1'b0, "R4 oe at 16th rise", 32'(sdat_oe), 32'h0);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
        end
        -> rd_ev;
        repeat (2) @(negedge clk);
    endtask

    task automatic prog_row();
        send_cmd(6'h08);
        repeat (6) @(negedge clk);
        send_cmd(6'h0E);
        repeat (4) @(negedge clk);
    endtask

    task automatic reenter();
        prog_en = 1'b0;
        repeat (3) @(negedge clk);
        prog_en = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", 32'h0, 32'h1);
        finish_run();
    end

    initial begin
        int b;
        logic [5:0] incc;
        rst_n = 1'b0; prog_en = 1'b0; sclk = 1'b0; sdat_in = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(sdat_oe == 1'b0 && erase_stb == 1'b0 && mem_we == 1'b0, "R11 reset quiet",
            {29'h0, sdat_oe, erase_stb, mem_we}, 32'h0);
        prog_en = 1'b1;
        repeat (2) @(negedge clk);

        // Phase A: configuration word visible at entry, erase, program a row.
        read_exp(14'h3FFF, "R6 config visible at entry");
        send_cmd(6'h39);  // erase code with don't-care upper bits set
        chk(er_cnt == 1, "R1 R10 erase with upper bits set", 32'(er_cnt), 32'h1);
        inc_n(1);         // 0xFFF -> 0x000
        load_word(14'h2123); inc_n(1);
        load_word(14'h1456); inc_n(1);
        load_word(14'h0789); inc_n(1);
        load_word(14'h3ABC);
        b = we_cnt;
        prog_row();
        chk(we_cnt - b == 4, "R8 four write strobes", 32'(we_cnt - b), 32'h4);
        inc_n(1);         // pc 4
        load_word(14'h00A5);
        send_cmd(6'h0E);  // clears the latch
        prog_row();
        read_exp(14'h3FFF, "R9 end programming cleared latch");

        // Phase B: program config word with protection on.
        reenter();
        load_word(14'h0FF7);
        prog_row();
        read_exp(14'h3FF7, "R6 config programmed and read");
        b = we_cnt;
        send_cmd(6'h0C); send_cmd(6'h3F); send_cmd(6'h01);
        chk(we_cnt == b && er_cnt == 1, "R2 unknown codes no strobe", 32'(we_cnt - b), 32'h0);
        read_exp(14'h3FF7, "R2 unknown codes left counter");
        inc_n(1);
        read_exp(14'h3123, "R5 R3 wrap to 0 and load discard");
        inc_n(1); read_exp(14'h3456, "R3 word 1");
        inc_n(1); read_exp(14'h3789, "R8 word 2");
        inc_n(1); read_exp(14'h3ABC, "R8 word 3");
        inc_n('h3C);
        read_exp(14'h3FFF, "R7 0x03F unprotected");
        inc_n(1);
        read_exp(14'h3000, "R7 0x040 protected");
        inc_n('h7BF);
        read_exp(14'h3000, "R7 0x7FF protected");
        inc_n(1);
        read_exp(14'h35A5, "R5 R7 0x7FF to 0x800 id readable");
        inc_n('h7FF);
        read_exp(14'h3FFF, "R6 0xFFF hidden after increment");
        load_word(14'h0000);
        b = we_cnt;
        prog_row();
        chk(we_cnt - b == 3, "R6 hidden word write suppressed", 32'(we_cnt - b), 32'h3);
        inc_n(1);
        read_exp(14'h3123, "R5 wrap 0xFFF to 0x000");

        // R11: partial command abandoned.
        bitclk(1'b0); bitclk(1'b1); bitclk(1'b1);
        prog_en = 1'b0;
        repeat (3) @(negedge clk);
        prog_en = 1'b1;
        repeat (2) @(negedge clk);
        read_exp(14'h3FF7, "R11 partial command abandoned");

        // R11: decode edge and enable drop in the same cycle.
        incc = 6'h06;
        for (int i = 0; i < 5; i++) bitclk(incc[i]);
        sdat_in = 1'b0;
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
        prog_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(sdat_oe == 1'b0 && mem_we == 1'b0, "R11 quiet while off",
            {30'h0, sdat_oe, mem_we}, 32'h0);
        prog_en = 1'b1;
        repeat (2) @(negedge clk);
        read_exp(14'h3FF7, "R11 decode with exit ignored");
        chk(exp_q.size() == 0, "R4 all reads seen", 32'(exp_q.size()), 32'h0);

        repeat (10) @(negedge clk);
        finish_run();
    end
endmodule